// File: doc/BRIEF.md
# Operand Bypass and Stall Controller

This block decides, for each instruction that sits in the operand-fetch stage of a five-stage in-order pipeline (fetch, decode, operand fetch, execute, write-back), where each source operand must come from. It keeps a short record of the destination registers of the older instructions still ahead of operand fetch. It compares both source register numbers of the waiting instruction against that record. It then steers each operand multiplexer to the register file, to the latched ALU output, or to the result bus. If no path can deliver a correct value yet, it raises a stall.

The controller tracks three slots ahead of operand fetch. Slot 1 holds the instruction now in execute; its result does not exist yet. Slot 2 holds the instruction in write-back; its ALU output is latched and can be bypassed. Slot 3 holds the instruction whose result is being driven onto the result bus and written into the register file. From slot 4 onward the value is read from the register file itself.

A two-bit mode input chooses the bypass scheme:

| Mode | Bypass paths used | Stall cycles for a back-to-back dependency |
|------|-------------------|--------------------------------------------|
| none | no bypass | 3 |
| bus only | result bus | 2 |
| full | ALU output and result bus | 1 |

A loaded value is never present at the ALU output, so a load in slot 2 still stalls its consumer. While the controller stalls, it inserts an empty slot ahead of the held instruction. It records that instruction only on the cycle in which it leaves operand fetch.

Top module: `fwd_ctrl`

## Requirements
- R1: While reset is held low, all three tracking slots are empty. After reset, a valid instruction with both sources in use, followed by no producer, sees stall low and both selects at register file (code 2'b00).
- R2: With mode 2'b00 (no bypass), a consumer issued right after a producer of its source register stalls for exactly 3 cycles, then selects the register file (2'b00).
- R3: With mode 2'b01 (result bus only), a back-to-back consumer stalls for exactly 2 cycles, then selects the result bus (2'b10).
- R4: With mode 2'b10 or 2'b11 (full bypass), a back-to-back consumer stalls for exactly 1 cycle, then selects the ALU output (2'b01).
- R5: In full bypass mode, a producer two instructions ahead is bypassed from the ALU output (2'b01) without stall. A producer three instructions ahead is bypassed from the result bus (2'b10) without stall. A producer four or more instructions ahead gives the register file (2'b00).
- R6: A load producer (load flag high) in slot 2 stalls its consumer even in full bypass mode. A back-to-back consumer of a load therefore stalls for 2 cycles, then selects the result bus (2'b10).
- R7: When slot 2 and slot 3 both hold producers of the same source register, the younger one (slot 2, ALU output 2'b01) is selected.
- R8: A producer whose destination is register 0, or whose write flag is low, never causes a stall or a bypass select.
- R9: Stall is low whenever the operand-fetch valid input is low, and a source whose use flag is low never causes a stall.
- R10: Each source is resolved on its own. Source B can be bypassed while source A reads the register file in the same cycle, and the select codes are limited to 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_mode | input | 2 | Bypass scheme: 00 none, 01 result bus only, 10/11 full |
| of_valid | input | 1 | Operand-fetch stage holds an instruction |
| of_src_a | input | 5 | Source A register number |
| of_use_a | input | 1 | Source A is read |
| of_src_b | input | 5 | Source B register number |
| of_use_b | input | 1 | Source B is read |
| of_dst | input | 5 | Destination register of the operand-fetch instruction |
| of_wr | input | 1 | Operand-fetch instruction writes a register |
| of_load | input | 1 | Operand-fetch instruction is a load |
| sel_a | output | 2 | Operand A multiplexer select |
| sel_b | output | 2 | Operand B multiplexer select |
| stall | output | 1 | Hold operand fetch and earlier stages this cycle |

## Verification
The assertions take for granted that the stages beyond operand fetch never stall. They also assume that the destination, write and load inputs describe the same instruction as the source inputs, and that those inputs stay constant while stall is high. The bench keeps within these assumptions: it drives a complete instruction on a falling edge and holds it unchanged until stall drops. It changes the mode only after idle cycles that empty all three slots.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    parameter int REG_AW    = 5;
    parameter int NUM_SLOTS = 3;

    localparam int SLOT_EX  = 0;
    localparam int SLOT_ALU = 1;
    localparam int SLOT_BUS = 2;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_ALU = 2'b01,
        SEL_BUS = 2'b10
    } opsel_e;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_BUS  = 2'b01,
        MODE_FULL = 2'b10,
        MODE_ALT  = 2'b11
    } fwd_mode_e;

    typedef struct packed {
        logic              live;
        logic              load;
        logic [REG_AW-1:0] dst;
    } slot_t;
endpackage

// File: rtl/fwd_slot_pipe.sv
module fwd_slot_pipe
    import fwd_pkg::*;
#(
    parameter int DEPTH = NUM_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              in_wr,
    input  logic              in_load,
    input  logic [REG_AW-1:0] in_dst,
    output slot_t             slots [DEPTH]
);
    slot_t entry;

    always_comb begin
        entry.live = issue && in_wr && (in_dst != '0);
        entry.load = issue && in_load;
        entry.dst  = in_dst;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots[0] <= '0;
        end else begin
            slots[0] <= entry;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else begin
                slots[g] <= slots[g-1];
            end
        end
    end
endmodule

// File: rtl/fwd_src_resolve.sv
module fwd_src_resolve
    import fwd_pkg::*;
#(
    parameter int DEPTH = NUM_SLOTS
) (
    input  logic [1:0]        mode,
    input  logic              use_src,
    input  logic [REG_AW-1:0] src,
    input  slot_t             slots [DEPTH],
    output opsel_e            sel,
    output logic              hold
);
    logic [DEPTH-1:0] hit;
    logic             alu_ok;
    logic             bus_ok;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = use_src && slots[g].live && (slots[g].dst == src) && (src != '0);
    end

    always_comb begin
        alu_ok = (mode == MODE_FULL) || (mode == MODE_ALT);
        bus_ok = (mode != MODE_NONE);
    end

    always_comb begin
        sel  = SEL_RF;
        hold = 1'b0;
        // oldest first so the youngest matching slot is assigned last
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel  = SEL_RF;
                hold = 1'b1;
                if (i == SLOT_ALU && alu_ok && !slots[i].load) begin
                    sel  = SEL_ALU;
                    hold = 1'b0;
                end else if (i == SLOT_BUS && bus_ok) begin
                    sel  = SEL_BUS;
                    hold = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
    import fwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fwd_mode,
    input  logic              of_valid,
    input  logic [REG_AW-1:0] of_src_a,
    input  logic              of_use_a,
    input  logic [REG_AW-1:0] of_src_b,
    input  logic              of_use_b,
    input  logic [REG_AW-1:0] of_dst,
    input  logic              of_wr,
    input  logic              of_load,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic              stall
);
    localparam int NSRC = 2;

    slot_t             slots [NUM_SLOTS];
    logic [REG_AW-1:0] src_v [NSRC];
    logic [NSRC-1:0]   use_v;
    logic [NSRC-1:0]   hold_v;
    opsel_e            sel_v [NSRC];
    logic              issue;

    assign src_v[0] = of_src_a;
    assign src_v[1] = of_src_b;
    assign use_v    = {of_use_b, of_use_a};

    always_comb begin
        stall = of_valid && (hold_v != '0);
        issue = of_valid && !stall;
    end

    fwd_slot_pipe #(.DEPTH(NUM_SLOTS)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (issue),
        .in_wr   (of_wr),
        .in_load (of_load),
        .in_dst  (of_dst),
        .slots   (slots)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        fwd_src_resolve #(.DEPTH(NUM_SLOTS)) u_res (
            .mode    (fwd_mode),
            .use_src (use_v[s]),
            .src     (src_v[s]),
            .slots   (slots),
            .sel     (sel_v[s]),
            .hold    (hold_v[s])
        );
    end

    assign sel_a = sel_v[0];
    assign sel_b = sel_v[1];
endmodule

// File: rtl/fwd_ctrl_checker.sv
module fwd_ctrl_checker
    import fwd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        fwd_mode,
    input logic              of_valid,
    input logic [REG_AW-1:0] of_src_a,
    input logic              of_use_a,
    input logic [REG_AW-1:0] of_dst,
    input logic              of_wr,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic              stall
);
    assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !of_valid |-> !stall);

    assert_legal_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11));

    assert_none_mode_rf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_mode == MODE_NONE) |-> (sel_a == SEL_RF && sel_b == SEL_RF));

    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (of_src_a == '0) |-> (sel_a == SEL_RF));

    assert_b2b_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(of_valid && !stall && of_wr && (of_dst != '0))
         && of_valid && of_use_a && (of_src_a == $past(of_dst))) |-> stall);
endmodule

bind fwd_ctrl fwd_ctrl_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_mode (fwd_mode),
    .of_valid (of_valid),
    .of_src_a (of_src_a),
    .of_use_a (of_use_a),
    .of_dst   (of_dst),
    .of_wr    (of_wr),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .stall    (stall)
);

// File: tb/fwd_ctrl_tb_top.sv
module fwd_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fwd_mode = 2'b00;
    logic       of_valid = 1'b0;
    logic [4:0] of_src_a = '0;
    logic       of_use_a = 1'b0;
    logic [4:0] of_src_b = '0;
    logic       of_use_b = 1'b0;
    logic [4:0] of_dst = '0;
    logic       of_wr = 1'b0;
    logic       of_load = 1'b0;
    logic [1:0] sel_a;
    logic [1:0] sel_b;
    logic       stall;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fwd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fwd_mode(fwd_mode), .of_valid(of_valid),
        .of_src_a(of_src_a), .of_use_a(of_use_a), .of_src_b(of_src_b),
        .of_use_b(of_use_b), .of_dst(of_dst), .of_wr(of_wr), .of_load(of_load),
        .sel_a(sel_a), .sel_b(sel_b), .stall(stall)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // present one instruction, hold it while stalled; report stall cycles and selects
    task automatic issue(input logic [4:0] dst, input logic wr, input logic ld,
                         input logic [4:0] sa, input logic ua,
                         input logic [4:0] sb, input logic ub,
                         output int stalls, output logic [1:0] qa, output logic [1:0] qb);
        @(negedge clk);
        of_valid = 1'b1; of_dst = dst; of_wr = wr; of_load = ld;
        of_src_a = sa; of_use_a = ua; of_src_b = sb; of_use_b = ub;
        #1;
        stalls = 0;
        while (stall && stalls < 10) begin
            @(negedge clk);
            #1;
            stalls++;
        end
        qa = sel_a;
        qb = sel_b;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        of_valid = 1'b0; of_wr = 1'b0; of_load = 1'b0; of_use_a = 1'b0; of_use_b = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        of_valid = 1'b1; of_use_a = 1'b1; of_use_b = 1'b1;
        of_src_a = 5'd3; of_src_b = 5'd4;
        #1;
        check("R1 stall", int'(stall), 0);
        check("R1 sel_a", int'(sel_a), 0);
        check("R1 sel_b", int'(sel_b), 0);
        idle(4);
    endtask

    task automatic t_b2b(input logic [1:0] m, input int exp_st, input int exp_sel, string req);
        int st; logic [1:0] qa, qb;
        fwd_mode = m;
        issue(5'd5, 1, 0, 5'd1, 0, 5'd2, 0, st, qa, qb);
        issue(5'd6, 1, 0, 5'd5, 1, 5'd2, 0, st, qa, qb);
        check({req, " stalls"}, st, exp_st);
        check({req, " sel"}, int'(qa), exp_sel);
        idle(4);
    endtask

    task automatic t_distance;
        int st; logic [1:0] qa, qb;
        fwd_mode = 2'b10;
        for (int d = 2; d <= 4; d++) begin
            issue(5'd9, 1, 0, 5'd1, 0, 5'd1, 0, st, qa, qb);
            for (int k = 1; k < d; k++) issue(5'd20, 1, 0, 5'd1, 0, 5'd1, 0, st, qa, qb);
            issue(5'd21, 1, 0, 5'd9, 1, 5'd1, 0, st, qa, qb);
            check("R5 stalls", st, 0);
            check("R5 sel", int'(qa), (d == 2) ? 1 : (d == 3) ? 2 : 0);
            idle(4);
        end
    endtask

    task automatic t_load;
        int st; logic [1:0] qa, qb;
        fwd_mode = 2'b11;
        issue(5'd11, 1, 1, 5'd1, 0, 5'd1, 0, st, qa, qb);
        issue(5'd12, 1, 0, 5'd11, 1, 5'd1, 0, st, qa, qb);
        check("R6 stalls", st, 2);
        check("R6 sel", int'(qa), 2);
        idle(4);
    endtask

    task automatic t_priority;
        int st; logic [1:0] qa, qb;
        fwd_mode = 2'b10;
        issue(5'd7, 1, 0, 5'd1, 0, 5'd1, 0, st, qa, qb);
        issue(5'd7, 1, 0, 5'd1, 0, 5'd1, 0, st, qa, qb);
        issue(5'd13, 1, 0, 5'd7, 1, 5'd1, 0, st, qa, qb);
        check("R7 stalls", st, 1);
        check("R7 sel", int'(qa), 1);
        idle(4);
    endtask

    task automatic t_nomatch;
        int st; logic [1:0] qa, qb;
        fwd_mode = 2'b10;
        issue(5'd0, 1, 0, 5'd1, 0, 5'd1, 0, st, qa, qb);
        issue(5'd14, 1, 0, 5'd0, 1, 5'd0, 1, st, qa, qb);
        check("R8 reg0 stalls", st, 0);
        check("R8 reg0 sel", int'(qa), 0);
        idle(4);
        issue(5'd15, 0, 0, 5'd1, 0, 5'd1, 0, st, qa, qb);
        issue(5'd14, 1, 0, 5'd15, 1, 5'd1, 0, st, qa, qb);
        check("R8 nowrite stalls", st, 0);
        check("R8 nowrite sel", int'(qa), 0);
        idle(4);
    endtask

    task automatic t_gating;
        int st; logic [1:0] qa, qb;
        fwd_mode = 2'b00;
        issue(5'd16, 1, 0, 5'd1, 0, 5'd1, 0, st, qa, qb);
        @(negedge clk);
        of_valid = 1'b0; of_src_a = 5'd16; of_use_a = 1'b1;
        #1;
        check("R9 invalid stall", int'(stall), 0);
        of_valid = 1'b1; of_use_a = 1'b0; of_src_b = 5'd16; of_use_b = 1'b0;
        #1;
        check("R9 unused stall", int'(stall), 0);
        idle(4);
    endtask

    task automatic t_indep;
        int st; logic [1:0] qa, qb;
        fwd_mode = 2'b10;
        issue(5'd9, 1, 0, 5'd1, 0, 5'd1, 0, st, qa, qb);
        issue(5'd20, 1, 0, 5'd1, 0, 5'd1, 0, st, qa, qb);
        issue(5'd21, 1, 0, 5'd3, 1, 5'd9, 1, st, qa, qb);
        check("R10 stalls", st, 0);
        check("R10 sel_a", int'(qa), 0);
        check("R10 sel_b", int'(qb), 1);
        idle(4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset stall", int'(stall), 0);
        rst_n = 1'b1;
        t_reset();
        t_b2b(2'b00, 3, 0, "R2");
        t_b2b(2'b01, 2, 2, "R3");
        t_b2b(2'b10, 1, 1, "R4");
        t_b2b(2'b11, 1, 1, "R4 alt");
        t_distance();
        t_load();
        t_priority();
        t_nomatch();
        t_gating();
        t_indep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule